// File: doc/BRIEF.md
# Speculative Load Alias Checker

This block keeps a small content-addressable record of loads that have produced their data ahead of older stores but have not yet committed. Each live record holds the load's effective address, the physical register number the load writes, and a valid bit. A load is recorded when it finishes. It is released when it commits, and the release is looked up by physical register number.

When a store commits, its address is compared against every live record. Every record that matches is a load that read memory too early. All such records are dropped. On the next cycle the block raises a squash request carrying the register number of the oldest matching load, where age is the order in which the loads were recorded. A squash may also hit a load that in fact read correct data; this is accepted. A full indication lets the issue logic hold back further speculative loads. A flush input empties the whole record. Pipeline recovery after a squash is handled elsewhere.

Top module: `flb_alias_checker`

## Requirements
- R1: After reset the buffer holds no entries, `full` is 0 and `sq_valid` is 0.
- R2: With `ins_valid` high and the buffer not full, the load is stored in a free entry at the clock edge. `full` is 1 exactly when all DEPTH entries are valid.
- R3: An insert while `full` is 1 is dropped. The dropped load never causes a squash.
- R4: With `rm_valid` high, every valid entry whose tag equals `rm_tag` is invalidated at the clock edge.
- R5: With `st_valid` high and at least one valid entry whose address equals `st_addr`, `sq_valid` is 1 in the next cycle. `sq_tag` then holds the tag of the earliest-inserted matching entry, and all matching entries are invalidated.
- R6: A cycle with `st_valid` low, or with no valid entry matching `st_addr`, gives `sq_valid` 0 in the next cycle and leaves the entries as they were.
- R7: Removal, the store check and the full test all use the state from before a same-cycle insert. A load inserted in the same cycle as a store to its address survives that store. An insert into a full buffer is dropped even when a same-cycle removal frees an entry.
- R8: `flush` invalidates every entry and forces `sq_valid` to 0 in the next cycle. It overrides any same-cycle insert, removal or store check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| ins_valid | input | 1 | Record a finished load |
| ins_addr | input | AW | Effective address of the finished load |
| ins_tag | input | TW | Physical register number of the finished load |
| rm_valid | input | 1 | A load commits |
| rm_tag | input | TW | Physical register number of the committing load |
| st_valid | input | 1 | A store commits |
| st_addr | input | AW | Address of the committing store |
| full | output | 1 | All entries valid; stall speculative loads |
| sq_valid | output | 1 | Squash request, one cycle after the store |
| sq_tag | output | TW | Register number of the oldest aliased load |

## Verification
The bench builds the block with DEPTH=4, AW=3 and TW=3. With these values a handful of inserts fills the buffer, so the full boundary and dropped inserts come up often. The eight addresses and eight tags collide frequently, which produces many multi-entry aliases and tests oldest-match selection across slot reuse. A long pseudo-random run is compared against an arithmetic model that records insertion stamps. Directed steps cover each corner named in the requirements.

// File: rtl/flb_alias_checker.sv
module flb_alias_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic [TW-1:0] ins_tag,
  input  logic          rm_valid,
  input  logic [TW-1:0] rm_tag,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  output logic          full,
  output logic          sq_valid,
  output logic [TW-1:0] sq_tag
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [TW-1:0]    tag_q  [DEPTH];
  logic [DEPTH-1:0] older  [DEPTH];   // older[i][j]: i was inserted before j

  logic [DEPTH-1:0] rm_hit, st_hit, first_hit, ins_oh;
  logic [IW-1:0]    ins_slot;
  logic [TW-1:0]    hit_tag;
  logic             ins_ok;

  assign full   = &vld;
  assign ins_ok = ins_valid && !full && !flush;

  always_comb begin
    ins_slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) ins_slot = IW'(i);
    ins_oh = '0;
    if (ins_ok) ins_oh[ins_slot] = 1'b1;
  end

  always_comb begin
    hit_tag = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rm_hit[i] = vld[i] && rm_valid && (tag_q[i] == rm_tag);
      st_hit[i] = vld[i] && st_valid && (addr_q[i] == st_addr);
    end
    for (int i = 0; i < DEPTH; i++) begin
      first_hit[i] = st_hit[i];
      for (int j = 0; j < DEPTH; j++)
        if (st_hit[j] && older[j][i]) first_hit[i] = 1'b0;
      if (first_hit[i]) hit_tag = hit_tag | tag_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld      <= '0;
      sq_valid <= 1'b0;
      sq_tag   <= '0;
    end else begin
      vld      <= (vld & ~rm_hit & ~st_hit) | ins_oh;
      sq_valid <= |st_hit;
      if (|st_hit) sq_tag <= hit_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_ok) begin
      addr_q[ins_slot] <= ins_addr;
      tag_q[ins_slot]  <= ins_tag;
      for (int j = 0; j < DEPTH; j++) older[j][ins_slot] <= 1'b1;
      older[ins_slot] <= '0;
    end
  end

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0) && !sq_valid);
  assert_full_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full && ins_valid && !rm_valid && !st_valid && !flush |=> $stable(vld));
  assert_insert_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !full && !rm_valid && !st_valid && !flush
    |=> $countones(vld) == $past($countones(vld)) + 1);
  assert_remove_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rm_valid && !flush |=> (vld & $past(rm_hit)) == '0);
  assert_squash_needs_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> $past(st_valid));
  assert_quiet_without_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !sq_valid);
endmodule

// File: tb/sim_flb_alias_checker.sv
module sim_flb_alias_checker;
  localparam int PERIOD = 10;
  localparam int D = 4, AW = 3, TW = 3;

  logic clk = 0, rst_n = 0, flush = 0, ins_valid = 0, rm_valid = 0, st_valid = 0;
  logic [AW-1:0] ins_addr = 0, st_addr = 0;
  logic [TW-1:0] ins_tag = 0, rm_tag = 0, sq_tag;
  logic full, sq_valid;

  int checks = 0, errors = 0;
  bit m_v [D];
  int m_a [D], m_t [D], m_s [D];
  int stamp = 0;
  int lcg = 12345;

  always #(PERIOD/2) clk = ~clk;

  flb_alias_checker #(.DEPTH(D), .AW(AW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .ins_tag(ins_tag), .rm_valid(rm_valid), .rm_tag(rm_tag), .st_valid(st_valid),
    .st_addr(st_addr), .full(full), .sq_valid(sq_valid), .sq_tag(sq_tag));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit ins, input int ia, input int it, input bit rm, input int rt,
                      input bit st, input int sa, input bit fl, input string req);
    int cnt, best, exp_tag, free_i;
    bit exp_sv;
    bit nv [D];
    @(negedge clk);
    ins_valid = ins; ins_addr = AW'(ia); ins_tag = TW'(it);
    rm_valid = rm; rm_tag = TW'(rt); st_valid = st; st_addr = AW'(sa); flush = fl;
    cnt = 0; best = -1; exp_tag = 0; exp_sv = 0; free_i = -1;
    for (int i = 0; i < D; i++) begin
      nv[i] = m_v[i];
      if (m_v[i]) cnt++; else if (free_i < 0) free_i = i;
      if (m_v[i] && rm && m_t[i] == rt) nv[i] = 0;
      if (m_v[i] && st && m_a[i] == sa) begin
        nv[i] = 0; exp_sv = 1;
        if (best < 0 || m_s[i] < m_s[best]) best = i;
      end
    end
    if (best >= 0) exp_tag = m_t[best];
    if (fl) begin
      exp_sv = 0;
      for (int i = 0; i < D; i++) nv[i] = 0;
    end else if (ins && cnt < D) begin
      nv[free_i] = 1; m_a[free_i] = ia; m_t[free_i] = it; m_s[free_i] = stamp++;
    end
    for (int i = 0; i < D; i++) m_v[i] = nv[i];
    @(posedge clk); #1;
    check(req, "sq_valid", int'(sq_valid), int'(exp_sv));
    if (exp_sv) check(req, "sq_tag", int'(sq_tag), exp_tag);
    cnt = 0;
    for (int i = 0; i < D; i++) if (m_v[i]) cnt++;
    check(req, "full", int'(full), int'(cnt == D));
  endtask

  function automatic int rnd(input int m);
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 16) & 32'h7fff) % m;
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) m_v[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "full", int'(full), 0);
    check("R1", "sq_valid", int'(sq_valid), 0);
    @(negedge clk); rst_n = 1;

    step(1, 1, 1, 0, 0, 0, 0, 0, "R2");
    step(1, 2, 2, 0, 0, 0, 0, 0, "R2");
    step(1, 3, 3, 0, 0, 0, 0, 0, "R2");
    step(1, 1, 4, 0, 0, 0, 0, 0, "R2");
    step(1, 5, 5, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 5, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R5");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R5");
    step(1, 6, 6, 0, 0, 1, 6, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 6, 0, "R7");
    step(0, 0, 0, 1, 2, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 2, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 7, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 3, 0, "R6");
    for (int k = 0; k < 4; k++) step(1, 4, k, 0, 0, 0, 0, 0, "R2");
    step(1, 4, 7, 1, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 4, 0, "R7");
    for (int k = 0; k < 3; k++) step(1, k, k, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 5, 0, 0, 1, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 5, 0, "R8");

    for (int n = 0; n < 4000; n++)
      step(rnd(4) != 0, rnd(8), rnd(8), rnd(3) == 0, rnd(8),
           rnd(3) == 0, rnd(8), rnd(60) == 0, "R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule